// File: doc/BRIEF.md
# Burst-Capable Bus Master Sequencer

This block sits between internal requesters and an external bus whose data pins are 64 bits wide. The slave behind those pins may use all 64 lanes, or only the lowest 32, 16 or 8. It accepts one request at a time and turns it into bus cycles. Each cycle has an active-low address strobe, a 32-bit address, a write flag and a count of active-low ready acknowledgements. Reads are packed into a 64-bit holding register. Write data is cut into port-sized slices, one slice per beat.

A cache-line fill or a DMA transfer always moves a whole line of four double words. The sequencer raises an active-low burst request in the same cycle as the first address strobe. If the slave answers with a burst acknowledge in the same cycle as the first ready, the line runs as one burst: one strobe, with the address stepping on every ready. If the acknowledge does not come, the same beats run as separate single transfers, each with its own strobe. All other accesses run as single transfers. For these, the number of transfers follows from the access size and the port width.

Top module: `burst_bus_master`

## Requirements
- R1: While reset is low, and in the first idle cycle after it, `bus_as_n` and `bus_breq_n` are high, `req_ready` is high and `req_done` is low. This also holds after a reset that arrives in the middle of a transfer.
- R2: A line operation asserts `bus_breq_n` low in exactly one cycle: the cycle of its first `bus_as_n` strobe. A line operation is a read with `req_kind`=1 (cached) and `req_asi` in 0x8..0xB, or any access with `req_kind`=2 (DMA), in both cases with `req_atomic` low.
- R3: When `bus_back_n` is low at the first ready of a line operation, the whole line runs with a single strobe. The beat-k address is the start address plus k times the port width in bytes, and it holds steady between readies.
- R4: When `bus_back_n` is high at the first ready, every beat runs as a separate transfer with its own strobe. The strobe lasts one cycle, and there is no further burst request.
- R5: A line operation takes 4, 8, 16 or 32 beats for `port_sel` = 0, 1, 2, 3 (64-, 32-, 16-, 8-bit port). It starts at the request address with the low 5 bits cleared.
- R6: Cached writes, atomic accesses and cached reads with `req_asi` outside 0x8..0xB never assert `bus_breq_n`. A burst acknowledge does not merge their transfers.
- R7: Other accesses start at `req_addr`. `req_size` is 0 for byte, 1 for halfword, 2 for word and 3 for double word. They take 1 transfer when the size is no larger than the port, and otherwise size divided by port width.
- R8: Narrow ports use the lowest data lanes. After a read, the low bytes of `rd_data` hold the last up to 8 bytes received. The byte at the lowest address sits in the most significant position.
- R9: Write data is taken big-endian from the low `req_size` bytes of `req_wdata` (a full double word for line operations). Beat k carries the next port-width bytes. The first of those bytes goes in the most significant active lane. Unused lanes are zero.
- R10: `req_done` pulses for one cycle, in the cycle after the last ready. `rd_dw_valid` pulses once per completed double word. During a line write, `line_idx` names the double word that `req_wdata` must present.
- R11: A request is accepted only while `req_ready` is high (idle). A request raised while busy changes neither the beat count nor the addresses of the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_sel | input | 2 | Port width: 0=64, 1=32, 2=16, 3=8 bits |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Idle, request will be taken |
| req_write | input | 1 | 1 = write |
| req_kind | input | 2 | 0 plain, 1 cached, 2 DMA |
| req_atomic | input | 1 | Atomic access |
| req_asi | input | 4 | Address-space identifier |
| req_size | input | 2 | Access size code |
| req_addr | input | 32 | Request byte address |
| req_wdata | input | 64 | Write data (current double word) |
| line_idx | output | 2 | Double word in progress |
| rd_data | output | 64 | Read holding register |
| rd_dw_valid | output | 1 | Double word completed |
| req_done | output | 1 | Transfer finished pulse |
| bus_as_n | output | 1 | Address strobe |
| bus_breq_n | output | 1 | Burst request |
| bus_addr | output | 32 | Bus address |
| bus_we | output | 1 | Write cycle |
| bus_wdata | output | 64 | Write data lanes |
| bus_rdata | input | 64 | Read data lanes |
| bus_rdy_n | input | 1 | Ready acknowledge |
| bus_back_n | input | 1 | Burst acknowledge |

## Verification
The bench runs line reads and writes on every port width, both with the burst granted and with it refused. A design that decided the burst at the strobe rather than at the first ready, or that issued fewer singles after a refusal, shows a wrong strobe or beat count. The bench grants a burst to plain accesses and to atomic and out-of-range cached reads; a design that let these merge would drop strobes. Line writes check each slice against the double word selected by `line_idx`, so a swapped lane or a skipped index is caught. A request held high during a busy line, and a reset in mid-transfer, expose a sequencer that re-accepts or keeps driving the bus.

// File: rtl/bmx_pkg.sv
// Shared types for the burst bus master sequencer.
// Assumes a 64-bit data path and a 2-bit port-width code (0=64 .. 3=8 bits).
package bmx_pkg;
    typedef enum logic [1:0] {
        KIND_PLAIN = 2'd0,
        KIND_CACHE = 2'd1,
        KIND_DMA   = 2'd2,
        KIND_RSVD  = 2'd3
    } kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } state_e;
endpackage

// File: rtl/bmx_plan.sv
// Transfer planner: classifies a request as a line operation or a single
// access, works out the total beat count for the port width and the start
// address. Purely combinational; assumes inputs are the request fields.
module bmx_plan #(
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 6,
    parameter int LINE_DWORDS = 4
) (
    input  logic [1:0]        kind,
    input  logic              write,
    input  logic              atomic,
    input  logic [3:0]        asi,
    input  logic [1:0]        size,
    input  logic [1:0]        psel,
    input  logic [ADDR_W-1:0] addr,
    output logic              is_line,
    output logic [CNT_W-1:0]  beats,
    output logic [ADDR_W-1:0] start_addr
);
    import bmx_pkg::*;
    localparam int LINE_BYTES = LINE_DWORDS * 8;

    logic       asi_ok;
    logic [1:0] log2w;

    // classify the request and size it in beats
    always_comb begin
        asi_ok  = (asi[3:2] == 2'b10);
        is_line = !atomic && (((kind == KIND_CACHE) && !write && asi_ok) || (kind == KIND_DMA));
        log2w   = 2'd3 - psel;
        if (is_line)
            beats = CNT_W'(LINE_DWORDS) << psel;
        else if (size > log2w)
            beats = CNT_W'(1) << (size - log2w);
        else
            beats = CNT_W'(1);
        start_addr = is_line ? (addr & ~ADDR_W'(LINE_BYTES - 1)) : addr;
    end
endmodule

// File: rtl/bmx_lanes.sv
// Data lane handling: shifts narrow read beats into a 64-bit holding
// register (earlier bytes end up more significant) and picks the write
// slice for the current beat out of left-justified request data.
// Assumes narrow ports use the lowest lanes of the data bus.
module bmx_lanes #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              fire,
    input  logic [1:0]        psel,
    input  logic              is_line,
    input  logic [1:0]        size,
    input  logic [2:0]        pos,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] rd_data
);
    localparam int SH_W = $clog2(DATA_W) + 1;

    logic [SH_W-1:0]   wbits, sbits, pshift;
    logic [DATA_W-1:0] rmask, just, moved;

    // lane widths, read mask and write slice selection
    always_comb begin
        wbits     = SH_W'(DATA_W) >> psel;
        rmask     = {DATA_W{1'b1}} >> (SH_W'(DATA_W) - wbits);
        sbits     = is_line ? SH_W'(DATA_W) : (SH_W'(8) << size);
        pshift    = SH_W'(pos) * wbits;
        just      = wdata << (SH_W'(DATA_W) - sbits);
        moved     = just << pshift;
        bus_wdata = moved >> (SH_W'(DATA_W) - wbits);
    end

    // shift each read beat into the holding register
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            rd_data <= '0;
        else if (fire)
            rd_data <= (rd_data << wbits) | (bus_rdata & rmask);
    end
endmodule

// File: rtl/burst_bus_master.sv
// Burst-capable bus master sequencer. Accepts one request while idle,
// strobes the address, offers a burst for line operations and settles
// burst-or-singles at the first ready. Assumes the slave acknowledge is
// meaningful only together with the first ready of a transaction.
module burst_bus_master #(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 64,
    parameter int LINE_DWORDS = 4,
    localparam int CNT_W      = $clog2(LINE_DWORDS * 8 + 1),
    localparam int LIDX_W     = (LINE_DWORDS > 1) ? $clog2(LINE_DWORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        port_sel,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_kind,
    input  logic              req_atomic,
    input  logic [3:0]        req_asi,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [LIDX_W-1:0] line_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_dw_valid,
    output logic              req_done,
    output logic              bus_as_n,
    output logic              bus_breq_n,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_we,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_rdy_n,
    input  logic              bus_back_n
);
    import bmx_pkg::*;
    localparam int BYTES = DATA_W / 8;

    state_e            state;
    logic              first_q, decided_q, burst_q, line_q, write_q;
    logic [1:0]        psel_q, size_q;
    logic [CNT_W-1:0]  beats_q, cnt_q;
    logic [ADDR_W-1:0] addr_q;

    logic              plan_line;
    logic [CNT_W-1:0]  plan_beats;
    logic [ADDR_W-1:0] plan_start;
    logic              accept, fire, last, burst_now;
    logic [2:0]        pmask, pos;

    bmx_plan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LINE_DWORDS(LINE_DWORDS)) plan_i (
        .kind(req_kind), .write(req_write), .atomic(req_atomic), .asi(req_asi),
        .size(req_size), .psel(port_sel), .addr(req_addr),
        .is_line(plan_line), .beats(plan_beats), .start_addr(plan_start)
    );

    bmx_lanes #(.DATA_W(DATA_W)) lanes_i (
        .clk(clk), .rst_n(rst_n), .clear(accept), .fire(fire), .psel(psel_q),
        .is_line(line_q), .size(size_q), .pos(pos), .wdata(req_wdata),
        .bus_rdata(bus_rdata), .bus_wdata(bus_wdata), .rd_data(rd_data)
    );

    // handshake, beat position and pin decode
    always_comb begin
        accept     = req_valid && (state == ST_IDLE);
        fire       = (state == ST_BUSY) && !bus_rdy_n;
        last       = (cnt_q == beats_q - CNT_W'(1));
        burst_now  = decided_q ? burst_q : (line_q && !bus_back_n);
        pmask      = 3'b111 >> (2'd3 - psel_q);
        pos        = cnt_q[2:0] & pmask;
        line_idx   = LIDX_W'(cnt_q >> psel_q);
        req_ready  = (state == ST_IDLE);
        bus_as_n   = !((state == ST_BUSY) && first_q);
        bus_breq_n = !((state == ST_BUSY) && first_q && line_q && !decided_q);
        bus_we     = (state == ST_BUSY) && write_q;
        bus_addr   = addr_q;
    end

    // transaction sequencer: accept, strobe, count readies, finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            first_q     <= 1'b0;
            decided_q   <= 1'b0;
            burst_q     <= 1'b0;
            line_q      <= 1'b0;
            write_q     <= 1'b0;
            psel_q      <= 2'd0;
            size_q      <= 2'd0;
            beats_q     <= '0;
            cnt_q       <= '0;
            addr_q      <= '0;
            req_done    <= 1'b0;
            rd_dw_valid <= 1'b0;
        end else begin
            req_done    <= 1'b0;
            rd_dw_valid <= 1'b0;
            if (accept) begin
                state     <= ST_BUSY;
                first_q   <= 1'b1;
                decided_q <= 1'b0;
                burst_q   <= 1'b0;
                line_q    <= plan_line;
                write_q   <= req_write;
                psel_q    <= port_sel;
                size_q    <= req_size;
                beats_q   <= plan_beats;
                cnt_q     <= '0;
                addr_q    <= plan_start;
            end else if (fire) begin
                decided_q   <= 1'b1;
                burst_q     <= burst_now;
                addr_q      <= addr_q + (ADDR_W'(BYTES) >> psel_q);
                rd_dw_valid <= (pos == pmask) || last;
                if (last) begin
                    state    <= ST_IDLE;
                    first_q  <= 1'b0;
                    req_done <= 1'b1;
                end else begin
                    cnt_q   <= cnt_q + CNT_W'(1);
                    first_q <= !burst_now;
                end
            end else if (state == ST_BUSY) begin
                first_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/bmx_checker.sv
// Protocol checker for the burst bus master, attached by bind.
module bmx_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              req_done,
    input logic              bus_as_n,
    input logic              bus_breq_n,
    input logic              bus_rdy_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              line_q
);
    p_breq_with_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_breq_n |-> !bus_as_n);
    p_breq_line_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_breq_n |-> line_q);
    p_strobe_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_as_n && bus_rdy_n) |=> bus_as_n);
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (bus_as_n && bus_breq_n));
    p_done_after_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |-> $past(!bus_rdy_n));
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |=> !req_done);
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready) && $past(bus_rdy_n)) |-> $stable(bus_addr));
endmodule

bind burst_bus_master bmx_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .req_done(req_done),
    .bus_as_n(bus_as_n), .bus_breq_n(bus_breq_n), .bus_rdy_n(bus_rdy_n),
    .bus_addr(bus_addr), .line_q(line_q)
);

// File: tb/burst_bus_master_tb_top.sv
module burst_bus_master_tb_top;
    typedef struct packed {
        logic [1:0]  psel;
        logic [1:0]  kind;
        logic        wr;
        logic        atom;
        logic [3:0]  asi;
        logic [1:0]  size;
        logic        grant;
        logic        poke;
        logic [31:0] addr;
        logic [5:0]  exp_beats;
        logic [5:0]  exp_strobes;
        logic        exp_line;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 2'd1, 1'b0, 1'b0, 4'h8, 2'd0, 1'b1, 1'b0, 32'h1000_0013, 6'd4,  6'd1,  1'b1},
        '{2'd1, 2'd1, 1'b0, 1'b0, 4'h9, 2'd3, 1'b1, 1'b1, 32'h2000_0040, 6'd8,  6'd1,  1'b1},
        '{2'd2, 2'd1, 1'b0, 1'b0, 4'hA, 2'd2, 1'b0, 1'b0, 32'h3000_0028, 6'd16, 6'd16, 1'b1},
        '{2'd3, 2'd2, 1'b0, 1'b0, 4'h0, 2'd3, 1'b1, 1'b0, 32'h4000_0060, 6'd32, 6'd1,  1'b1},
        '{2'd3, 2'd2, 1'b1, 1'b0, 4'h0, 2'd3, 1'b0, 1'b0, 32'h5000_0080, 6'd32, 6'd32, 1'b1},
        '{2'd2, 2'd2, 1'b1, 1'b0, 4'h0, 2'd3, 1'b1, 1'b0, 32'h5000_01A0, 6'd16, 6'd1,  1'b1},
        '{2'd1, 2'd1, 1'b0, 1'b0, 4'h4, 2'd2, 1'b1, 1'b0, 32'h6000_0104, 6'd1,  6'd1,  1'b0},
        '{2'd0, 2'd1, 1'b1, 1'b0, 4'h8, 2'd3, 1'b1, 1'b0, 32'h6000_0208, 6'd1,  6'd1,  1'b0},
        '{2'd3, 2'd0, 1'b1, 1'b0, 4'h8, 2'd3, 1'b1, 1'b0, 32'h7000_0010, 6'd8,  6'd8,  1'b0},
        '{2'd2, 2'd0, 1'b0, 1'b0, 4'h8, 2'd2, 1'b1, 1'b0, 32'h7000_0024, 6'd2,  6'd2,  1'b0},
        '{2'd3, 2'd0, 1'b0, 1'b0, 4'h8, 2'd1, 1'b1, 1'b0, 32'h7000_0032, 6'd2,  6'd2,  1'b0},
        '{2'd3, 2'd0, 1'b0, 1'b0, 4'h8, 2'd0, 1'b1, 1'b0, 32'h7000_0047, 6'd1,  6'd1,  1'b0},
        '{2'd1, 2'd0, 1'b0, 1'b0, 4'h8, 2'd3, 1'b1, 1'b0, 32'h7000_0058, 6'd2,  6'd2,  1'b0},
        '{2'd0, 2'd1, 1'b0, 1'b1, 4'hB, 2'd3, 1'b1, 1'b0, 32'h7000_0060, 6'd1,  6'd1,  1'b0},
        '{2'd2, 2'd1, 1'b0, 1'b0, 4'hC, 2'd1, 1'b1, 1'b0, 32'h7000_0072, 6'd1,  6'd1,  1'b0},
        '{2'd2, 2'd0, 1'b1, 1'b0, 4'h0, 2'd2, 1'b0, 1'b0, 32'h7000_0084, 6'd2,  6'd2,  1'b0},
        '{2'd0, 2'd2, 1'b0, 1'b1, 4'h0, 2'd3, 1'b1, 1'b0, 32'h7000_0098, 6'd1,  6'd1,  1'b0},
        '{2'd3, 2'd0, 1'b1, 1'b0, 4'h0, 2'd0, 1'b0, 1'b0, 32'h7000_00A5, 6'd1,  6'd1,  1'b0},
        '{2'd0, 2'd0, 1'b1, 1'b0, 4'h0, 2'd0, 1'b1, 1'b0, 32'h7000_00B3, 6'd1,  6'd1,  1'b0}
    };
    localparam logic [63:0] WD_FIXED = 64'hA1B2_C3D4_E5F6_0718;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  port_sel = 2'd0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic        req_atomic = 1'b0;
    logic [3:0]  req_asi = 4'h0;
    logic [1:0]  req_size = 2'd0;
    logic [31:0] req_addr = 32'h0;
    logic [63:0] req_wdata;
    logic [1:0]  line_idx;
    logic [63:0] rd_data;
    logic        rd_dw_valid, req_done, bus_as_n, bus_breq_n, bus_we;
    logic [31:0] bus_addr;
    logic [63:0] bus_wdata;
    logic [63:0] bus_rdata = 64'h0;
    logic        bus_rdy_n = 1'b1;
    logic        bus_back_n = 1'b1;
    logic        line_mode = 1'b0;
    int          checks = 0;
    int          errors = 0;
    bit          finished = 1'b0;

    always #2 clk = ~clk;

    function automatic logic [63:0] line_pat(input int i);
        return 64'h1122_3344_5566_7788 + 64'h0101_0101_0101_0101 * 64'(i);
    endfunction

    function automatic logic [7:0] mb(input logic [31:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction

    assign req_wdata = line_mode ? line_pat(int'(line_idx)) : WD_FIXED;

    burst_bus_master dut_i (
        .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .req_valid(req_valid),
        .req_ready(req_ready), .req_write(req_write), .req_kind(req_kind),
        .req_atomic(req_atomic), .req_asi(req_asi), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata), .line_idx(line_idx),
        .rd_data(rd_data), .rd_dw_valid(rd_dw_valid), .req_done(req_done),
        .bus_as_n(bus_as_n), .bus_breq_n(bus_breq_n), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rdy_n(bus_rdy_n), .bus_back_n(bus_back_n)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // slave read data: byte at lowest address in the top active lane
    function automatic logic [63:0] slave_data(input logic [31:0] a, input int w);
        logic [63:0] r = {8{8'hEE}};
        for (int j = 0; j < w; j++) r[8*(w-1-j) +: 8] = mb(a + 32'(j));
        return r;
    endfunction

    function automatic logic [63:0] exp_wdata(input int k, input int w, input int sb, input bit line);
        logic [63:0] r = '0;
        for (int j = 0; j < w; j++) begin
            int idx;
            logic [7:0] b;
            if (line) begin
                idx = (k % (8 / w)) * w + j;
                b = line_pat(k / (8 / w)) >> (8 * (7 - idx));
            end else begin
                idx = k * w + j;
                b = (idx < sb) ? 8'(WD_FIXED >> (8 * (sb - 1 - idx))) : 8'h00;
            end
            r[8*(w-1-j) +: 8] = b;
        end
        return r;
    endfunction

    task automatic run_vec(input vec_t v);
        int w, sb, beats, strobes, breqs, breq_bad, aerr, werr, busy_bad, dws, total, nb;
        bit done_seen;
        logic [31:0] start;
        logic [63:0] expr, maskr;
        w = 8 >> v.psel;
        sb = v.exp_line ? 8 : (1 << v.size);
        start = v.exp_line ? {v.addr[31:5], 5'd0} : v.addr;
        beats = 0; strobes = 0; breqs = 0; breq_bad = 0; aerr = 0; werr = 0;
        busy_bad = 0; dws = 0; done_seen = 1'b0;
        @(negedge clk);
        port_sel = v.psel; req_kind = v.kind; req_write = v.wr; req_atomic = v.atom;
        req_asi = v.asi; req_size = v.size; req_addr = v.addr; req_valid = 1'b1;
        line_mode = v.exp_line; bus_rdy_n = 1'b1; bus_back_n = !v.grant;
        @(negedge clk);
        for (int cyc = 0; cyc < 300; cyc++) begin
            if (v.poke) begin
                req_valid = 1'b1; req_kind = 2'd0; req_size = 2'd0; req_addr = 32'hFFFF_FF00;
            end else begin
                req_valid = 1'b0;
            end
            if (rd_dw_valid) dws++;
            if (req_done) begin done_seen = 1'b1; break; end
            if (req_ready) busy_bad++;
            if (!bus_as_n) strobes++;
            if (!bus_breq_n) begin breqs++; if (bus_as_n) breq_bad++; end
            bus_rdy_n = (cyc == 0);
            if (!bus_rdy_n) begin
                if (bus_addr != start + 32'(beats * w)) aerr++;
                if (v.wr) begin
                    if (bus_wdata !== exp_wdata(beats, w, sb, v.exp_line)) werr++;
                end else begin
                    bus_rdata = slave_data(bus_addr, w);
                end
                beats++;
            end
            @(negedge clk);
        end
        req_valid = 1'b0; bus_rdy_n = 1'b1;
        check(done_seen, "R10", "done seen", 64'(done_seen), 64'd1);
        check(beats == int'(v.exp_beats), v.exp_line ? "R5" : "R7", "beat count", 64'(beats), 64'(v.exp_beats));
        check(strobes == int'(v.exp_strobes), (v.exp_line && v.grant) ? "R3" : "R4", "strobe count",
              64'(strobes), 64'(v.exp_strobes));
        check(breqs == int'(v.exp_line), v.exp_line ? "R2" : "R6", "burst requests", 64'(breqs), 64'(v.exp_line));
        check(breq_bad == 0, "R2", "burst request without strobe", 64'(breq_bad), 64'd0);
        check(aerr == 0, "R3", "address errors", 64'(aerr), 64'd0);
        check(busy_bad == 0, "R11", "ready while busy", 64'(busy_bad), 64'd0);
        check(dws == (v.exp_line ? 4 : 1), "R10", "double word pulses", 64'(dws), v.exp_line ? 64'd4 : 64'd1);
        if (v.wr) begin
            check(werr == 0, "R9", "write slice errors", 64'(werr), 64'd0);
        end else begin
            total = beats * w;
            nb = (total < 8) ? total : 8;
            expr = '0;
            for (int i = 0; i < nb; i++) expr[8*i +: 8] = mb(start + 32'(total - 1 - i));
            maskr = (nb == 8) ? {64{1'b1}} : ((64'd1 << (8 * nb)) - 64'd1);
            check((rd_data & maskr) == expr, "R8", "read packing", rd_data & maskr, expr);
        end
        @(negedge clk);
        check(!req_done, "R10", "done one cycle", 64'(req_done), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(bus_as_n && bus_breq_n, "R1", "bus idle in reset", {62'd0, bus_as_n, bus_breq_n}, 64'd3);
        check(req_ready && !req_done, "R1", "ready in reset", {62'd0, req_ready, req_done}, 64'd2);
        rst_n = 1'b1;
        @(negedge clk);
        check(bus_as_n && bus_breq_n && req_ready, "R1", "idle after reset",
              {61'd0, bus_as_n, bus_breq_n, req_ready}, 64'd7);
        for (int n = 0; n < NV; n++) run_vec(VEC[n]);
        // reset in the middle of a DMA line
        @(negedge clk);
        port_sel = 2'd3; req_kind = 2'd2; req_write = 1'b0; req_atomic = 1'b0;
        req_size = 2'd3; req_addr = 32'h0800_0000; req_valid = 1'b1; bus_rdy_n = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; bus_rdy_n = 1'b0;
        repeat (3) @(negedge clk);
        bus_rdy_n = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        check(bus_as_n && bus_breq_n && req_ready, "R1", "reset mid transfer",
              {61'd0, bus_as_n, bus_breq_n, req_ready}, 64'd7);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !req_done, "R1", "idle after mid reset", {62'd0, req_ready, req_done}, 64'd2);
        run_vec(VEC[0]);
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule